// File: doc/BRIEF.md
# Symmetric Transparent March Self-Test Controller

This block runs a non-destructive march test over a word-wide synchronous single-port RAM while the RAM keeps its working contents. Each write stores the complement of the word read one cycle earlier from the same address. After an even number of such writes every word again holds its original value. The test never writes a fixed pattern, so it can run in the field between periods of normal use.

Every word read from the RAM, inverted or not depending on the march element, is compacted into a multi-input signature register. The register steps forward during the first half of the march and runs its exact inverse step during the second half. The march is arranged so that the second-half stream is the first-half stream in reverse order. A fault-free memory therefore returns the register to its seed, and no separate pass is needed to learn the expected signature. The default march takes 10n memory operations for n words. A parameter selects a shorter 4n variant.

Software or a test sequencer pulses `start`, waits for `done` and reads `pass`. The RAM port is driven only while `busy` is high.

Top module: `revsig_march_bist`

## Requirements
- R1: After reset `busy`, `done`, `pass`, `ramEn` and `ramWe` are low and `sigOut` equals the parameter `SIG_SEED`.
- R2: A `start` pulse seen while idle launches six elements in this order, one memory operation per cycle. E1 goes ascending and reads. E2 and E3 go ascending and do read then write. E4 and E5 go descending and do read then write. E6 goes descending and reads. Ascending runs from address 0 to all-ones and descending runs the other way. In a read-then-write element the write hits the same address in the cycle right after the read. The next address's read follows the write in the cycle after that.
- R3: Every write drives `ramWdata` equal to the bitwise complement of the `ramRdata` word returned for the read issued in the previous cycle.
- R4: When the march finishes on a fault-free RAM, every word holds the value it had before `start`.
- R5: `busy` stays high for exactly 10n+2 cycles, where n = 2^ADDR_W. `done` then rises with `busy` low and stays high until the next accepted `start`. `pass` is valid whenever `done` is high.
- R6: The word read by E1, E4, E5 and E6 is inverted before compaction, and the word read by E2 and E3 is fed unchanged. Words from E1 to E3 step the signature forward and words from E4 to E6 step it in reverse. The register is loaded with `SIG_SEED` on an accepted `start`. `pass` is 1 exactly when the final state equals `SIG_SEED`, and a fault-free RAM gives `pass` = 1 with `sigOut` = `SIG_SEED`.
- R7: A RAM with one bit stuck at a fixed value gives `pass` = 0.
- R8: With `SHORT_MARCH` = 1 the march is two elements. The first goes ascending and does read then write, feeding the word unchanged and stepping forward. The second goes descending and does read then write, feeding the inverted word and stepping in reverse. `busy` lasts 4n+2 cycles, the contents are restored, and a fault-free RAM passes.
- R9: `start` while `busy` is high has no effect: the operation sequence and the busy length are unchanged.
- R10: The signature holds unless a word is fed. The word d is zero-extended to SIG_W bits. A forward step maps state s to {d[W-1] ^ parity(s & SIG_TAPS), d[W-2:0] ^ s[W-1:1]}. A reverse step is the exact inverse of that map for the same d. SIG_TAPS bit 0 must be 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted only while idle |
| busy | output | 1 | March in progress |
| done | output | 1 | Last march finished; held until the next start |
| pass | output | 1 | Signature returned to seed (valid with done) |
| ramEn | output | 1 | RAM access enable |
| ramWe | output | 1 | RAM write enable (read when low) |
| ramAddr | output | ADDR_W | RAM word address |
| ramWdata | output | DATA_W | RAM write data |
| ramRdata | input | DATA_W | RAM read data, valid the cycle after a read |
| sigOut | output | SIG_W | Current signature register state |

## Verification
A wrong element index or address counter shows up at once on the RAM port as an operation at the wrong address, of the wrong kind or in the wrong direction. The bench model compares every access cycle, so such an error is seen within a cycle of going wrong. Wrong feed inversion, a wrong step direction or a bad reverse step does not reach the memory port. It shows only at the end, as `pass` disagreeing with the bench's own prediction, which compares a forward-only compaction of the first-half stream against one of the reversed second-half stream. A stuck cell and the 4n variant check that the end-of-march decision and the restored contents hold in both march shapes.

// File: rtl/revsig_march_pkg.sv
package revsig_march_pkg;

  // Static description of one march element.
  typedef struct packed {
    logic desc;      // walk addresses downwards
    logic hasWrite;  // read followed by write on each address
    logic feedInv;   // invert the read word before compaction
    logic rev;       // signature steps in reverse
    logic wrInv;     // write the complement of the read word
  } elemCfg_t;

  // Strobes from control to datapath, one cycle at a time.
  typedef struct packed {
    logic seedLoad;
    logic rdIssue;
    logic wrIssue;
    logic feedInv;
    logic rev;
    logic wrInv;
  } strobe_t;

  localparam int ELEM_IDX_W = 3;

  function automatic elemCfg_t elemCfg(input logic shortMarch,
                                       input logic [ELEM_IDX_W-1:0] idx);
    elemCfg_t c;
    c = '{desc: 1'b0, hasWrite: 1'b0, feedInv: 1'b0, rev: 1'b0, wrInv: 1'b1};
    if (shortMarch) begin
      case (idx)
        3'd0:    c = '{desc: 1'b0, hasWrite: 1'b1, feedInv: 1'b0, rev: 1'b0, wrInv: 1'b1};
        default: c = '{desc: 1'b1, hasWrite: 1'b1, feedInv: 1'b1, rev: 1'b1, wrInv: 1'b1};
      endcase
    end else begin
      case (idx)
        3'd0:    c = '{desc: 1'b0, hasWrite: 1'b0, feedInv: 1'b1, rev: 1'b0, wrInv: 1'b1};
        3'd1:    c = '{desc: 1'b0, hasWrite: 1'b1, feedInv: 1'b0, rev: 1'b0, wrInv: 1'b1};
        3'd2:    c = '{desc: 1'b0, hasWrite: 1'b1, feedInv: 1'b0, rev: 1'b0, wrInv: 1'b1};
        3'd3:    c = '{desc: 1'b1, hasWrite: 1'b1, feedInv: 1'b1, rev: 1'b1, wrInv: 1'b1};
        3'd4:    c = '{desc: 1'b1, hasWrite: 1'b1, feedInv: 1'b1, rev: 1'b1, wrInv: 1'b1};
        default: c = '{desc: 1'b1, hasWrite: 1'b0, feedInv: 1'b1, rev: 1'b1, wrInv: 1'b1};
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/revsig_misr.sv
module revsig_misr #(
  parameter int                SIG_W    = 16,
  parameter logic [SIG_W-1:0]  SIG_TAPS = 16'h100B,
  parameter logic [SIG_W-1:0]  SIG_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  input  logic             rev,
  input  logic [SIG_W-1:0] din,
  output logic [SIG_W-1:0] state
);

  logic             fwdTop;
  logic [SIG_W-1:0] fwdNxt;
  logic [SIG_W-2:0] prvHigh;
  logic             prvLow;
  logic [SIG_W-1:0] revPrv;

  // Forward: shift toward bit 0, feedback parity into the top bit.
  assign fwdTop = din[SIG_W-1] ^ (^(state & SIG_TAPS));
  assign fwdNxt = {fwdTop, din[SIG_W-2:0] ^ state[SIG_W-1:1]};

  // Reverse: undo the shift first, then recover bit 0 from the feedback
  // equation (tap 0 is required to be set).
  assign prvHigh = din[SIG_W-2:0] ^ state[SIG_W-2:0];
  assign prvLow  = state[SIG_W-1] ^ din[SIG_W-1] ^ (^(prvHigh & SIG_TAPS[SIG_W-1:1]));
  assign revPrv  = {prvHigh, prvLow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     state <= SIG_SEED;
    else if (load) state <= SIG_SEED;
    else if (step) state <= rev ? revPrv : fwdNxt;
  end

  AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !step) |=> $stable(state));                                     // R10
  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (state == SIG_SEED));                                            // R6

endmodule

// File: rtl/revsig_march_dp.sv
module revsig_march_dp
  import revsig_march_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter int               SIG_W    = 16,
  parameter logic [SIG_W-1:0] SIG_TAPS = 16'h100B,
  parameter logic [SIG_W-1:0] SIG_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [DATA_W-1:0] ramWdata,
  output logic [SIG_W-1:0]  sigOut,
  output logic              sigAtSeed
);

  logic              feedValid;
  logic              feedInvQ;
  logic              revQ;
  logic [DATA_W-1:0] feedWord;
  logic [SIG_W-1:0]  feedWide;

  // The read word arrives one cycle after the read strobe; keep the
  // element flags aligned with it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      feedValid <= 1'b0;
      feedInvQ  <= 1'b0;
      revQ      <= 1'b0;
    end else begin
      feedValid <= strb.rdIssue;
      feedInvQ  <= strb.feedInv;
      revQ      <= strb.rev;
    end
  end

  assign ramWdata = strb.wrInv ? ~ramRdata : ramRdata;
  assign feedWord = feedInvQ ? ~ramRdata : ramRdata;
  assign feedWide = SIG_W'(feedWord);

  revsig_misr #(
    .SIG_W    (SIG_W),
    .SIG_TAPS (SIG_TAPS),
    .SIG_SEED (SIG_SEED)
  ) uMisr (
    .clk   (clk),
    .rstN  (rstN),
    .load  (strb.seedLoad),
    .step  (feedValid),
    .rev   (revQ),
    .din   (feedWide),
    .state (sigOut)
  );

  assign sigAtSeed = (sigOut == SIG_SEED);

endmodule

// File: rtl/revsig_march_ctrl.sv
module revsig_march_ctrl
  import revsig_march_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter bit SHORT_MARCH = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              sigAtSeed,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output strobe_t           strb
);

  localparam int                  NUM_ELEM = SHORT_MARCH ? 2 : 6;
  localparam logic [ADDR_W-1:0]   TOP_ADDR = '1;
  localparam logic [ELEM_IDX_W-1:0] LAST_ELEM = ELEM_IDX_W'(NUM_ELEM - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_DRAIN, S_CHECK} state_t;

  state_t                state, stateNxt;
  logic [ELEM_IDX_W-1:0] elem, elemNxt;
  logic [ADDR_W-1:0]     addr, addrNxt;
  logic                  doneR, passR;
  logic                  advance;
  logic                  lastAddr, lastElem;
  elemCfg_t              cfg, cfgNext, cfgFirst;

  assign cfg      = elemCfg(SHORT_MARCH, elem);
  assign cfgNext  = elemCfg(SHORT_MARCH, elem + 1'b1);
  assign cfgFirst = elemCfg(SHORT_MARCH, '0);
  assign lastAddr = cfg.desc ? (addr == '0) : (addr == TOP_ADDR);
  assign lastElem = (elem == LAST_ELEM);

  always_comb begin
    stateNxt = state;
    elemNxt  = elem;
    addrNxt  = addr;
    advance  = 1'b0;
    ramEn    = 1'b0;
    ramWe    = 1'b0;
    strb     = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strb.seedLoad = 1'b1;
          elemNxt       = '0;
          addrNxt       = cfgFirst.desc ? TOP_ADDR : '0;
          stateNxt      = S_RD;
        end
      end
      S_RD: begin
        ramEn        = 1'b1;
        strb.rdIssue = 1'b1;
        strb.feedInv = cfg.feedInv;
        strb.rev     = cfg.rev;
        if (cfg.hasWrite) stateNxt = S_WR;
        else              advance  = 1'b1;
      end
      S_WR: begin
        ramEn        = 1'b1;
        ramWe        = 1'b1;
        strb.wrIssue = 1'b1;
        strb.wrInv   = cfg.wrInv;
        advance      = 1'b1;
      end
      S_DRAIN: stateNxt = S_CHECK;
      S_CHECK: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase

    if (advance) begin
      if (lastAddr) begin
        if (lastElem) begin
          stateNxt = S_DRAIN;
        end else begin
          elemNxt  = elem + 1'b1;
          addrNxt  = cfgNext.desc ? TOP_ADDR : '0;
          stateNxt = S_RD;
        end
      end else begin
        addrNxt  = cfg.desc ? (addr - 1'b1) : (addr + 1'b1);
        stateNxt = S_RD;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      elem  <= '0;
      addr  <= '0;
      doneR <= 1'b0;
      passR <= 1'b0;
    end else begin
      state <= stateNxt;
      elem  <= elemNxt;
      addr  <= addrNxt;
      if (state == S_IDLE && start) begin
        doneR <= 1'b0;
        passR <= 1'b0;
      end else if (state == S_CHECK) begin
        doneR <= 1'b1;
        passR <= sigAtSeed;
      end
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = doneR;
  assign pass    = passR;
  assign ramAddr = addr;

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ($past(ramEn && !ramWe) && (ramAddr == $past(ramAddr))));      // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ramEn && !ramWe && $past(ramEn) && (elem == $past(elem)))
      |-> ((ramAddr == $past(ramAddr) + 1'b1) || (ramAddr == $past(ramAddr) - 1'b1)));  // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);                                                          // R5
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramEn && busy));                                               // R3

endmodule

// File: rtl/revsig_march_bist.sv
module revsig_march_bist
  import revsig_march_pkg::*;
#(
  parameter int               DATA_W      = 8,
  parameter int               ADDR_W      = 11,
  parameter int               SIG_W       = 16,
  parameter logic [SIG_W-1:0] SIG_TAPS    = 16'h100B,
  parameter logic [SIG_W-1:0] SIG_SEED    = 16'hACE1,
  parameter bit               SHORT_MARCH = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [SIG_W-1:0]  sigOut
);

  strobe_t strb;
  logic    sigAtSeed;

  revsig_march_ctrl #(
    .ADDR_W      (ADDR_W),
    .SHORT_MARCH (SHORT_MARCH)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .sigAtSeed (sigAtSeed),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .ramEn     (ramEn),
    .ramWe     (ramWe),
    .ramAddr   (ramAddr),
    .strb      (strb)
  );

  revsig_march_dp #(
    .DATA_W   (DATA_W),
    .SIG_W    (SIG_W),
    .SIG_TAPS (SIG_TAPS),
    .SIG_SEED (SIG_SEED)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .ramRdata  (ramRdata),
    .ramWdata  (ramWdata),
    .sigOut    (sigOut),
    .sigAtSeed (sigAtSeed)
  );

endmodule

// File: tb/revsig_march_bist_test.sv
module revsig_ram_model #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          stuckEn,
  input  logic [AW-1:0] stuckAddr,
  input  int            stuckBit,
  input  logic          stuckVal
);
  logic [DW-1:0] mem [2**AW];

  function automatic logic [DW-1:0] readFix(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = mem[a];
    if (stuckEn && a == stuckAddr) v[stuckBit] = stuckVal;
    return v;
  endfunction

  initial rdata = '0;
  always @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata <= readFix(addr);
    end
  end
endmodule

module revsig_march_bist_test;
  localparam int DW = 8;
  localparam int AW = 11;
  localparam int N  = 2 ** AW;
  localparam int AWS = 4;
  localparam int NS  = 2 ** AWS;
  localparam logic [15:0] TAPS = 16'h100B;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int vecs = 0;
  int errs = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- main instance (six-element march) ----------------
  logic          start = 1'b0;
  logic          busy, done, pass, ramEn, ramWe;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramWdata, rdata;
  logic [15:0]   sigOut;
  logic          stuckEn = 1'b0;

  revsig_march_bist #(.DATA_W(DW), .ADDR_W(AW), .SIG_W(16), .SIG_TAPS(TAPS),
                      .SIG_SEED(SEED), .SHORT_MARCH(1'b0)) uut (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .pass(pass),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .ramRdata(rdata), .sigOut(sigOut));

  revsig_ram_model #(.DW(DW), .AW(AW)) ram (
    .clk(clk), .en(ramEn), .we(ramWe), .addr(ramAddr), .wdata(ramWdata), .rdata(rdata),
    .stuckEn(stuckEn), .stuckAddr(AW'(100)), .stuckBit(2), .stuckVal(1'b1));

  // ---------------- short-march instance ----------------
  logic           startS = 1'b0;
  logic           busyS, doneS, passS, ramEnS, ramWeS;
  logic [AWS-1:0] ramAddrS;
  logic [DW-1:0]  ramWdataS, rdataS;
  logic [15:0]    sigOutS;

  revsig_march_bist #(.DATA_W(DW), .ADDR_W(AWS), .SIG_W(16), .SIG_TAPS(TAPS),
                      .SIG_SEED(SEED), .SHORT_MARCH(1'b1)) uutShort (
    .clk(clk), .rstN(rstN), .start(startS), .busy(busyS), .done(doneS), .pass(passS),
    .ramEn(ramEnS), .ramWe(ramWeS), .ramAddr(ramAddrS), .ramWdata(ramWdataS),
    .ramRdata(rdataS), .sigOut(sigOutS));

  revsig_ram_model #(.DW(DW), .AW(AWS)) ramS (
    .clk(clk), .en(ramEnS), .we(ramWeS), .addr(ramAddrS), .wdata(ramWdataS), .rdata(rdataS),
    .stuckEn(1'b0), .stuckAddr('0), .stuckBit(0), .stuckVal(1'b0));

  // ---------------- reference model ----------------
  typedef struct {
    logic [AW-1:0] addr;
    bit            wr;
    bit            inv;
    bit            half2;
  } op_t;

  op_t           expQ[$];
  logic [DW-1:0] s1[$];
  logic [DW-1:0] s2[$];
  logic [DW-1:0] orig[N];
  bit            monOn = 1'b0;
  bit            pend = 1'b0, pendInv, pendHalf;
  int            busyCnt;
  op_t           e;
  logic [DW-1:0] w;

  // Element table of the march (R2, R6).
  bit tDesc [6] = '{0, 0, 0, 1, 1, 1};
  bit tWr   [6] = '{0, 1, 1, 1, 1, 0};
  bit tInv  [6] = '{1, 0, 0, 1, 1, 1};
  bit tHalf [6] = '{0, 0, 0, 1, 1, 1};

  task automatic buildQ();
    op_t o;
    expQ.delete();
    for (int el = 0; el < 6; el++) begin
      for (int k = 0; k < N; k++) begin
        o.addr  = AW'(tDesc[el] ? (N - 1 - k) : k);
        o.inv   = tInv[el];
        o.half2 = tHalf[el];
        o.wr    = 1'b0;
        expQ.push_back(o);
        if (tWr[el]) begin
          o.wr = 1'b1;
          expQ.push_back(o);
        end
      end
    end
  endtask

  // R10 forward step, written from the requirement.
  function automatic logic [15:0] fwdStep(input logic [15:0] s, input logic [DW-1:0] word);
    logic [15:0] d, n;
    d = 16'(word);
    for (int j = 0; j < 15; j++) n[j] = d[j] ^ s[j+1];
    n[15] = d[15] ^ (^(s & TAPS));
    return n;
  endfunction

  always @(negedge clk) begin
    if (monOn) begin
      if (pend) begin
        w = pendInv ? ~rdata : rdata;
        if (pendHalf) s2.push_back(w);
        else          s1.push_back(w);
        pend = 1'b0;
      end
      if (busy) busyCnt++;
      if (ramEn) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 stray memory operation", {ramWe, ramAddr}, 0);
        end else begin
          e = expQ.pop_front();
          chk(ramAddr == e.addr && ramWe == e.wr, "R2 operation kind/address",
              {ramWe, ramAddr}, {e.wr, e.addr});
          if (e.wr) chk(ramWdata == ~rdata, "R3 write data", ramWdata, ~rdata);
          else begin
            pend     = 1'b1;
            pendInv  = e.inv;
            pendHalf = e.half2;
          end
        end
      end
    end
  end

  task automatic runMarch(input int patSel, input bit fault, input bit midStart);
    logic [15:0] x, y;
    bit expPass;
    int bad;
    for (int i = 0; i < N; i++) begin
      orig[i]    = DW'((i * (37 + 2 * patSel)) ^ (i >> 3) ^ (patSel * 91));
      ram.mem[i] = orig[i];
    end
    buildQ();
    s1.delete();
    s2.delete();
    busyCnt = 0;
    pend    = 1'b0;
    stuckEn = fault;
    monOn   = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (midStart) begin
      repeat (57) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    monOn = 1'b0;
    chk(expQ.size() == 0, "R5 all operations issued", expQ.size(), 0);
    chk(busyCnt == 10 * N + 2, midStart ? "R9 busy length with start while busy" : "R5 busy length",
        busyCnt, 10 * N + 2);
    chk(!busy, "R5 busy low with done", busy, 0);
    x = SEED;
    foreach (s1[i]) x = fwdStep(x, s1[i]);
    y = SEED;
    for (int i = s2.size() - 1; i >= 0; i--) y = fwdStep(y, s2[i]);
    expPass = (x == y) && (s1.size() == s2.size());
    chk(pass == expPass, "R6 pass vs model", pass, expPass);
    if (!fault) begin
      chk(pass == 1'b1, "R6 fault-free pass", pass, 1);
      chk(sigOut == SEED, "R6 signature back at seed", sigOut, SEED);
      bad = 0;
      for (int i = 0; i < N; i++) if (ram.mem[i] !== orig[i]) bad++;
      chk(bad == 0, "R4 contents restored", bad, 0);
    end else begin
      chk(pass == 1'b0, "R7 stuck bit detected", pass, 0);
    end
    stuckEn = 1'b0;
  endtask

  task automatic runShort();
    logic [DW-1:0] origS [NS];
    int bc, ops, bad;
    for (int i = 0; i < NS; i++) begin
      origS[i]    = DW'(i * 53 + 7);
      ramS.mem[i] = origS[i];
    end
    bc = 0;
    ops = 0;
    @(negedge clk); startS = 1'b1;
    @(negedge clk); startS = 1'b0;
    while (!doneS) begin
      if (busyS) bc++;
      if (ramEnS) ops++;
      @(negedge clk);
    end
    chk(bc == 4 * NS + 2, "R8 short march busy length", bc, 4 * NS + 2);
    chk(ops == 4 * NS, "R8 short march operation count", ops, 4 * NS);
    chk(passS == 1'b1, "R8 short march pass", passS, 1);
    chk(sigOutS == SEED, "R8 short march signature at seed", sigOutS, SEED);
    bad = 0;
    for (int i = 0; i < NS; i++) if (ramS.mem[i] !== origS[i]) bad++;
    chk(bad == 0, "R8 short march contents restored", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && pass == 0, "R1 idle outputs", {busy, done, pass}, 0);
    chk(ramEn == 0 && ramWe == 0, "R1 RAM port quiet", {ramEn, ramWe}, 0);
    chk(sigOut == SEED, "R1 signature seed", sigOut, SEED);
    runMarch(0, 1'b0, 1'b0);
    chk(done == 1'b1, "R5 done held", done, 1);
    runMarch(1, 1'b0, 1'b1);
    runMarch(0, 1'b1, 1'b0);
    runShort();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=done", vecs);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule